// File: doc/BRIEF.md
# Dual-Mode Convolution Multiply-Accumulate Engine

This block is the arithmetic core of a tiled convolution accelerator. On each accepted beat it takes one pixel from each of TN input channels together with a TN-by-TM block of weights. For every one of TM kernels it multiplies each channel pixel by that kernel's weight for the channel, sums the TN products, and adds the sum to that kernel's running accumulator. An output pixel is complete after KS*KS*C beats, where KS is the kernel size and C is the number of channel tiles. The TM results then leave on a valid/ready output stream.

A mode input selects standard or depthwise convolution. Both modes use the same multiplier array. In depthwise mode every product whose channel differs from its kernel index is forced to zero, so that kernel m only sees channel m. A stride input picks 1 or 2. Together with the fixed input tile edge and the kernel size, the stride sets how many output pixels make up one tile: the output edge is (IN_TILE-KS)/stride+1. Tiles do not depend on each other. An upstream feeder presents the window data in order and the engine only counts beats.

Top module: `dmconv_engine`

## Requirements
- R1: In standard mode (mode input 0), output lane m (bits [m*AW +: AW] of out_data) equals the running sum, over the beats of one output pixel, of the sum over n of pix[n]*w[n][m]. Pixel n is at in_pix[n*8 +: 8] and weight (n,m) is at in_wgt[(n*TM+m)*8 +: 8], all signed.
- R2: In depthwise mode (mode input 1), output lane m accumulates only pix[m]*w[m][m]. All weights with n different from m have no effect on the output.
- R3: Every addition into a 24-bit accumulator saturates. A result above 8388607 becomes 8388607 and a result below -8388608 becomes -8388608, and accumulation then continues from the clipped value.
- R4: Accumulators start from zero for each output pixel. Exactly one output is produced per KS*KS*C accepted beats (KS=3), where C is the channel-tile count input, with 0 treated as 1.
- R5: A tile holds 16 output pixels at stride 1 (stride input 0, 6x6 input tile) and 4 output pixels at stride 2 (stride input 1, 5x5 of the 6x6 tile used). out_tile_last is 1 on exactly the final output of each tile.
- R6: Mode, stride and channel-tile count are taken only on the first accepted beat of a tile. Changes on the later beats of that tile have no effect.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1, out_data does not change, and in_ready is 0.
- R8: After reset, out_valid is 0 and in_ready is 1. With no output backpressure, one beat is accepted per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Engine can take a beat |
| in_pix | input | TN*8 | One signed pixel per input channel |
| in_wgt | input | TN*TM*8 | Signed weight block, channel-major |
| in_mode | input | 1 | 0 standard, 1 depthwise (sampled at tile start) |
| in_stride2 | input | 1 | 0 stride 1, 1 stride 2 (sampled at tile start) |
| in_ctiles | input | 4 | Channel tiles per output pixel (sampled at tile start) |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output |
| out_data | output | TM*24 | One signed accumulator per kernel |
| out_tile_last | output | 1 | Output is the last of its tile |

## Verification
Two things can happen in the same cycle. A finished pixel can wait on the output while the next pixel's first beats are already clearing and refilling the accumulators. At the same moment, the mode, stride and tile-count inputs can be changing under a tile that is in progress. The bench provokes both by throttling out_ready with random and long stall patterns while it feeds beats back to back, and by driving random mode, stride and tile-count values on every beat except the first of each tile. A scoreboard model sums the products with its own clamping and pops the expected result for each output handshake. It also checks at every stalled cycle that the data is held and that in_ready is low.

// File: rtl/dmconv_pkg.sv
`timescale 1ns/1ps
package dmconv_pkg;

  typedef enum logic {
    CONV_STD = 1'b0,
    CONV_DW  = 1'b1
  } conv_mode_e;

  // Output edge of one tile for a given input tile edge, kernel and stride.
  function automatic int out_span(input int tile_in, input int ksz, input bit half);
    return half ? ((tile_in - ksz) / 2) + 1 : (tile_in - ksz) + 1;
  endfunction

  // Largest number of beats that can make up one output pixel.
  function automatic int max_beats(input int ksz, input int ctw);
    return ksz * ksz * ((1 << ctw) - 1);
  endfunction

endpackage

// File: rtl/dmconv_dot_lane.sv
`timescale 1ns/1ps
module dmconv_dot_lane
  import dmconv_pkg::*;
#(
  parameter int TN   = 4,
  parameter int TM   = 4,
  parameter int DW   = 8,
  parameter int PW   = 18,
  parameter int LANE = 0
) (
  input  logic [TN*DW-1:0]      pix,
  input  logic [TN*TM*DW-1:0]   wgt,
  input  conv_mode_e            mode,
  output logic signed [PW-1:0]  psum
);

  localparam int PRW = 2 * DW;

  function automatic logic signed [PRW-1:0] mul8(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return $signed(a) * $signed(b);
  endfunction

  logic signed [PRW-1:0] prod [TN];

  for (genvar n = 0; n < TN; n++) begin : g_chan
    // Depthwise: only the channel matching this kernel contributes (zero fill).
    logic keep;
    assign keep    = (mode == CONV_STD) || (n == LANE);
    assign prod[n] = keep ? mul8(pix[n*DW +: DW], wgt[(n*TM+LANE)*DW +: DW]) : '0;
  end

  always_comb begin
    psum = '0;
    for (int n = 0; n < TN; n++) begin
      psum = psum + {{(PW-PRW){prod[n][PRW-1]}}, prod[n]};
    end
  end

endmodule

// File: rtl/dmconv_seq.sv
`timescale 1ns/1ps
module dmconv_seq
  import dmconv_pkg::*;
#(
  parameter int KS      = 3,
  parameter int IN_TILE = 6,
  parameter int CTW     = 4,
  parameter int BCW     = 8,
  parameter int PCW     = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            in_mode,
  input  logic            in_stride2,
  input  logic [CTW-1:0]  in_ctiles,
  output conv_mode_e      eff_mode,
  output logic            pix_first,
  output logic            pix_last,
  output logic            tile_last
);

  localparam int OD1 = out_span(IN_TILE, KS, 1'b0);
  localparam int OD2 = out_span(IN_TILE, KS, 1'b1);

  logic [BCW-1:0] beat_cnt;
  logic [PCW-1:0] pix_cnt;
  conv_mode_e     mode_q;
  logic           s2_q;
  logic [CTW-1:0] nct_q;

  logic           tile_start;
  logic           eff_s2;
  logic [CTW-1:0] eff_nct;
  logic [CTW-1:0] nct_nz;
  logic [BCW-1:0] bpp;
  logic [PCW-1:0] npix;

  assign tile_start = (beat_cnt == '0) && (pix_cnt == '0);
  assign eff_mode   = tile_start ? conv_mode_e'(in_mode) : mode_q;
  assign eff_s2     = tile_start ? in_stride2 : s2_q;
  assign eff_nct    = tile_start ? in_ctiles  : nct_q;
  assign nct_nz     = (eff_nct == '0) ? CTW'(1) : eff_nct;

  always_comb begin
    bpp  = BCW'(KS * KS) * BCW'(nct_nz);
    npix = eff_s2 ? PCW'(OD2 * OD2) : PCW'(OD1 * OD1);
  end

  assign pix_first = (beat_cnt == '0);
  assign pix_last  = (beat_cnt == bpp - BCW'(1));
  assign tile_last = pix_last && (pix_cnt == npix - PCW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_cnt <= '0;
      pix_cnt  <= '0;
      mode_q   <= CONV_STD;
      s2_q     <= 1'b0;
      nct_q    <= CTW'(1);
    end else if (accept) begin
      if (tile_start) begin
        mode_q <= conv_mode_e'(in_mode);
        s2_q   <= in_stride2;
        nct_q  <= in_ctiles;
      end
      if (pix_last) begin
        beat_cnt <= '0;
        pix_cnt  <= tile_last ? '0 : pix_cnt + PCW'(1);
      end else begin
        beat_cnt <= beat_cnt + BCW'(1);
      end
    end
  end

  // R4: the beat counter never passes the window length in force
  a_r4_beat_range: assert property (@(posedge clk) disable iff (!rst_n)
    beat_cnt < bpp);

  // R5: the final pixel of a tile returns both counters to the tile start
  a_r5_tile_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    accept && tile_last |=> (beat_cnt == '0) && (pix_cnt == '0));

  // R6: beats after the first of a tile leave the sampled settings alone
  a_r6_settings_held: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !tile_start |=> $stable(mode_q) && $stable(s2_q) && $stable(nct_q));

endmodule

// File: rtl/dmconv_accum.sv
`timescale 1ns/1ps
module dmconv_accum #(
  parameter int TM = 4,
  parameter int PW = 18,
  parameter int AW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic              s_first,
  input  logic              s_plast,
  input  logic              s_tlast,
  input  logic [TM*PW-1:0]  s_psum,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [TM*AW-1:0]  out_data,
  output logic              out_tlast,
  output logic              load_out
);

  localparam logic signed [AW-1:0] ACC_MAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] ACC_MIN = {1'b1, {(AW-1){1'b0}}};

  function automatic logic signed [AW-1:0] sat_add(input logic signed [AW-1:0] a,
                                                   input logic signed [AW-1:0] b);
    logic signed [AW:0] s;
    s = {a[AW-1], a} + {b[AW-1], b};
    if (s[AW] != s[AW-1]) return s[AW] ? ACC_MIN : ACC_MAX;
    return s[AW-1:0];
  endfunction

  function automatic logic signed [AW-1:0] widen(input logic [PW-1:0] p);
    return {{(AW-PW){p[PW-1]}}, p};
  endfunction

  assign load_out = s_valid && s_plast;

  for (genvar m = 0; m < TM; m++) begin : g_lane
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] nxt;
    logic signed [AW-1:0] inc;

    assign inc = widen(s_psum[m*PW +: PW]);
    assign nxt = s_first ? inc : sat_add(acc, inc);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc                  <= '0;
        out_data[m*AW +: AW] <= '0;
      end else begin
        if (s_valid)  acc                  <= nxt;
        if (load_out) out_data[m*AW +: AW] <= nxt;
      end
    end

    // R3: an accumulator pinned at the top stays there under non-negative input
    a_r3_pin_max: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid && !s_first && (acc == ACC_MAX) && !inc[AW-1] |=> acc == ACC_MAX);

    // R3: an accumulator pinned at the bottom stays there under negative input
    a_r3_pin_min: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid && !s_first && (acc == ACC_MIN) && inc[AW-1] |=> acc == ACC_MIN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_tlast <= 1'b0;
    end else if (load_out) begin
      out_valid <= 1'b1;
      out_tlast <= s_tlast;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7: a pending output is held with stable contents
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_tlast));

  // R7: no new result may land on a pending output
  a_r7_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !load_out);

endmodule

// File: rtl/dmconv_engine.sv
`timescale 1ns/1ps
module dmconv_engine
  import dmconv_pkg::*;
#(
  parameter int TN      = 4,
  parameter int TM      = 4,
  parameter int DW      = 8,
  parameter int AW      = 24,
  parameter int KS      = 3,
  parameter int IN_TILE = 6,
  parameter int CTW     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [TN*DW-1:0]      in_pix,
  input  logic [TN*TM*DW-1:0]   in_wgt,
  input  logic                  in_mode,
  input  logic                  in_stride2,
  input  logic [CTW-1:0]        in_ctiles,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [TM*AW-1:0]      out_data,
  output logic                  out_tile_last
);

  localparam int PW  = 2 * DW + $clog2(TN);
  localparam int OD1 = out_span(IN_TILE, KS, 1'b0);
  localparam int BCW = $clog2(max_beats(KS, CTW) + 1);
  localparam int PCW = $clog2(OD1 * OD1 + 1);

  logic             accept;
  conv_mode_e       eff_mode;
  logic             pix_first;
  logic             pix_last;
  logic             tile_last;
  logic             load_out;
  logic [TM*PW-1:0] psum_vec;

  logic             s1_v;
  logic             s1_first;
  logic             s1_plast;
  logic             s1_tlast;
  logic [TM*PW-1:0] s1_psum;

  assign in_ready = !(out_valid && !out_ready);
  assign accept   = in_valid && in_ready;

  dmconv_seq #(
    .KS(KS), .IN_TILE(IN_TILE), .CTW(CTW), .BCW(BCW), .PCW(PCW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .in_mode   (in_mode),
    .in_stride2(in_stride2),
    .in_ctiles (in_ctiles),
    .eff_mode  (eff_mode),
    .pix_first (pix_first),
    .pix_last  (pix_last),
    .tile_last (tile_last)
  );

  for (genvar m = 0; m < TM; m++) begin : g_kern
    dmconv_dot_lane #(
      .TN(TN), .TM(TM), .DW(DW), .PW(PW), .LANE(m)
    ) u_lane (
      .pix (in_pix),
      .wgt (in_wgt),
      .mode(eff_mode),
      .psum(psum_vec[m*PW +: PW])
    );
  end

  // Stage 1: registered channel reductions with their beat position
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_first <= 1'b0;
      s1_plast <= 1'b0;
      s1_tlast <= 1'b0;
      s1_psum  <= '0;
    end else begin
      s1_v <= accept;
      if (accept) begin
        s1_first <= pix_first;
        s1_plast <= pix_last;
        s1_tlast <= tile_last;
        s1_psum  <= psum_vec;
      end
    end
  end

  dmconv_accum #(
    .TM(TM), .PW(PW), .AW(AW)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_valid  (s1_v),
    .s_first  (s1_first),
    .s_plast  (s1_plast),
    .s_tlast  (s1_tlast),
    .s_psum   (s1_psum),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_tlast(out_tile_last),
    .load_out (load_out)
  );

  // R4: the last beat of a pixel reaches the output two cycles later
  a_r4_emit_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept && pix_last |-> ##2 out_valid);

  // R5: a tile-final beat is flagged on its output
  a_r5_last_flag: assert property (@(posedge clk) disable iff (!rst_n)
    accept && tile_last |-> ##2 out_tile_last);

  // R8: a beat accepted while the output is free is never refused downstream
  a_r8_no_stall_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

// File: tb/dmconv_engine_bench.sv
`timescale 1ns/1ps
module dmconv_engine_bench;

  localparam int TN = 4;
  localparam int TM = 4;
  localparam int DW = 8;
  localparam int AW = 24;
  localparam int CTW = 4;
  localparam int LIMIT = 150000;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [TN*DW-1:0]    in_pix = '0;
  logic [TN*TM*DW-1:0] in_wgt = '0;
  logic                in_mode = 1'b0;
  logic                in_stride2 = 1'b0;
  logic [CTW-1:0]      in_ctiles = '0;
  logic                out_valid;
  logic                out_ready = 1'b1;
  logic [TM*AW-1:0]    out_data;
  logic                out_tile_last;

  always #5 clk = ~clk;

  dmconv_engine u_dmconv_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_wgt(in_wgt), .in_mode(in_mode), .in_stride2(in_stride2),
    .in_ctiles(in_ctiles), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_tile_last(out_tile_last)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int bp_mode = 0;
  bit started = 0;

  logic [TM*AW-1:0] q_data [$];
  bit               q_last [$];
  string            q_tag  [$];

  // Output throttling: 0 always ready, 1 random, 2 rarely ready
  always @(posedge clk) begin
    #2;
    case (bp_mode)
      0: out_ready = 1'b1;
      1: out_ready = ($urandom_range(3) != 0);
      default: out_ready = ($urandom_range(15) == 0);
    endcase
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, got %0d cycles expected at most %0d", cycles, LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Monitor / scoreboard
  logic [TM*AW-1:0] prev_data;
  bit               prev_stall = 0;
  always @(negedge clk) begin
    if (rst_n && started) begin
      if (prev_stall) begin
        checks++;
        if (!(out_valid === 1'b1 && out_data === prev_data)) begin
          fails++;
          $display("FAIL R7 hold: valid=%0b data=%h expected valid=1 data=%h", out_valid, out_data, prev_data);
        end
      end
      if (out_valid && !out_ready) begin
        checks++;
        if (in_ready !== 1'b0) begin
          fails++;
          $display("FAIL R7 in_ready under stall: got %0b expected 0", in_ready);
        end
      end
      if (out_valid && out_ready) begin
        if (q_data.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL R4 unexpected output: got data=%h expected none", out_data);
        end else begin
          logic [TM*AW-1:0] ed;
          bit el;
          string et;
          ed = q_data.pop_front();
          el = q_last.pop_front();
          et = q_tag.pop_front();
          checks++;
          if (out_data !== ed) begin
            fails++;
            $display("FAIL %s data: got %h expected %h", et, out_data, ed);
          end
          checks++;
          if (out_tile_last !== el) begin
            fails++;
            $display("FAIL R5 tile_last: got %0b expected %0b", out_tile_last, el);
          end
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  function automatic int clamp24(input int v);
    if (v > 8388607)  return 8388607;
    if (v < -8388608) return -8388608;
    return v;
  endfunction

  function automatic logic [DW-1:0] pick(input int kind);
    case (kind)
      1: return 8'sd127;
      2: return 8'h80;
      default: return DW'($urandom);
    endcase
  endfunction

  task automatic drive_beat(input logic [TN*DW-1:0] p, input logic [TN*TM*DW-1:0] w,
                            input bit tfirst, input bit md, input bit s2, input int nct);
    if ($urandom_range(7) == 0) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_pix   = TN*DW'($urandom);
      in_mode  = 1'($urandom);
    end
    @(negedge clk);
    in_pix   = p;
    in_wgt   = w;
    in_valid = 1'b1;
    if (tfirst) begin
      in_mode    = md;
      in_stride2 = s2;
      in_ctiles  = CTW'(nct);
    end else begin
      in_mode    = 1'($urandom);
      in_stride2 = 1'($urandom);
      in_ctiles  = CTW'($urandom);
    end
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  // One tile: the model sums products with its own clamping per addition.
  task automatic run_tile(input bit md, input bit s2, input int nct,
                          input int pk, input int wk, input string tag);
    int edge_n = s2 ? 2 : 4;
    int nbeats = 9 * ((nct == 0) ? 1 : nct);
    for (int px = 0; px < edge_n * edge_n; px++) begin
      int acc [TM];
      logic [TM*AW-1:0] ev;
      for (int m = 0; m < TM; m++) acc[m] = 0;
      for (int b = 0; b < nbeats; b++) begin
        logic [TN*DW-1:0] p;
        logic [TN*TM*DW-1:0] w;
        for (int n = 0; n < TN; n++) p[n*DW +: DW] = pick(pk);
        for (int k = 0; k < TN*TM; k++) w[k*DW +: DW] = pick(wk);
        for (int m = 0; m < TM; m++) begin
          int s = 0;
          for (int n = 0; n < TN; n++) begin
            if (!md || n == m)
              s += int'($signed(p[n*DW +: DW])) * int'($signed(w[(n*TM+m)*DW +: DW]));
          end
          acc[m] = (b == 0) ? s : clamp24(acc[m] + s);
        end
        drive_beat(p, w, (px == 0 && b == 0), md, s2, nct);
      end
      for (int m = 0; m < TM; m++) ev[m*AW +: AW] = AW'(acc[m]);
      q_data.push_back(ev);
      q_last.push_back(px == edge_n * edge_n - 1);
      q_tag.push_back(tag);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 400 && q_data.size() != 0; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R8: reset state
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R8 out_valid after reset: got %0b expected 0", out_valid);
    end
    checks++;
    if (in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R8 in_ready after reset: got %0b expected 1", in_ready);
    end
    started = 1;

    // R1, R4, R5, R6: standard, stride 1, one channel tile
    bp_mode = 0;
    run_tile(1'b0, 1'b0, 1, 0, 0, "R1,R4,R6");
    // R2: depthwise, stride 1, two channel tiles, random off-diagonal weights
    run_tile(1'b1, 1'b0, 2, 0, 0, "R2,R6");
    // R1, R7: standard, stride 2, three tiles, random backpressure
    bp_mode = 1;
    run_tile(1'b0, 1'b1, 3, 0, 0, "R1,R7");
    // R2, R7: depthwise, stride 2, count 0 meaning 1, long stalls
    bp_mode = 2;
    run_tile(1'b1, 1'b1, 0, 0, 0, "R2,R4,R7");
    // R3: saturation at both ends
    bp_mode = 1;
    run_tile(1'b0, 1'b1, 15, 1, 1, "R3 max");
    run_tile(1'b0, 1'b1, 15, 2, 1, "R3 min");
    // R8: back-to-back beats without backpressure
    bp_mode = 0;
    run_tile(1'b1, 1'b0, 1, 0, 0, "R2,R8");
    drain();

    // R4: every expected output appeared, none left over
    checks++;
    if (q_data.size() != 0) begin
      fails++;
      $display("FAIL R4 missing outputs: got %0d pending expected 0", q_data.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule